// File: doc/BRIEF.md
# Run-time sized FIFO with level flags

This block is a synchronous first-in first-out store of 32-bit words held in 32 physical slots. The number of slots it actually uses is chosen while the chip runs, from a configuration write. That write carries a frame width and a large-mode bit. In large mode, narrow frames get many entries and wide frames get few. Outside large mode the store always holds four entries. A serial controller places one copy on its transmit side and one on its receive side.

Each cycle the block accepts at most one write and one read. Status outputs report:
- empty;
- full, meaning the level has reached the usable capacity;
- one-below-full;
- a one-cycle pulse for a write that was refused;
- a one-cycle pulse for a read of an empty store.

A clear input empties the store at once. The usable capacity and the current level are both available as outputs. Read data comes from a register and is valid on the cycle after the read request.

Top module: `adaptive_fifo`

## Requirements
- R1: After reset, and after any configuration write with `cfg_big`=0, `cap` is 4, whatever the frame width.
- R2: A configuration write with `cfg_big`=1 sets `cap` from `cfg_frame_size`, an unsigned bit count: 32 for a width of 8 or less, 16 for a width of 9 to 16, and 8 for a width of 17 or more.
- R3: A write request without a read, made while `level` >= `cap`, is dropped. It leaves `level` and the stored words unchanged, and `push_drop` is 1 on the following cycle.
- R4: `full_next` is 1 exactly when `level` equals `cap`-1.
- R5: `full` is 1 exactly when `level` >= `cap`. After an accepted write, `empty` is 0.
- R6: A read request while `level` is 0 gives `pop_data`=0 and `pop_err`=1 on the next cycle. `level` stays at 0.
- R7: When `clear` is 1, all read and write requests in that cycle are ignored. On the next cycle `level` is 0, `empty` is 1 and `full` is 0.
- R8: `cap` changes only on a cycle with `cfg_we`=1. Lowering `cap` below `level` discards no word, and `full` stays 1 until `level` falls below the new `cap`.
- R9: A read and a write in the same cycle while `level` > 0 leave `level` unchanged, and the write is kept, even when `full` is 1.
- R10: Words leave in the order they were accepted. The word taken by a read appears on `pop_data` on the cycle after the request.
- R11: After reset `level` is 0, `empty` is 1, and `full`, `full_next`, `pop_err` and `push_drop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Empty the store this cycle |
| cfg_we | input | 1 | Load a new capacity from cfg_big and cfg_frame_size |
| cfg_big | input | 1 | Large mode select |
| cfg_frame_size | input | 6 | Frame width in bits |
| push | input | 1 | Write request |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Read request |
| pop_data | output | 32 | Word read, valid on the cycle after pop |
| pop_err | output | 1 | Pulse: the previous read found the store empty |
| push_drop | output | 1 | Pulse: the previous write was refused |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level has reached the capacity |
| full_next | output | 1 | Level is one below the capacity |
| level | output | 6 | Number of stored words |
| cap | output | 6 | Usable capacity |

## Verification
Fill-and-drain runs at the four-entry capacity and at a sixteen-entry capacity show that the flags follow the level in both modes. The same runs show whether a refused write corrupts the stored order. Read-and-write pairs on a full store show that the full-state exception admits the new word without losing the old ones. Every frame width on both sides of the 8/9 and 16/17 thresholds is written, and so is a width given while large mode is off; these separate the three large-mode capacities from the small one. Lowering the capacity under a deep level, and pulsing clear together with a request, show that the level and the order survive the reconfiguration and that clear takes priority.

// File: rtl/adaptive_fifo.sv
module adaptive_fifo #(
  parameter int WIDTH      = 32,
  parameter int SLOTS      = 32,
  parameter int FSW        = 6,
  parameter int SMALL_CAP  = 4,
  parameter int NARROW_MAX = 8,
  parameter int MID_MAX    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cfg_we,
  input  logic             cfg_big,
  input  logic [FSW-1:0]   cfg_frame_size,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_err,
  output logic             push_drop,
  output logic             empty,
  output logic             full,
  output logic             full_next,
  output logic [$clog2(SLOTS):0] level,
  output logic [$clog2(SLOTS):0] cap
);
  localparam int AW = $clog2(SLOTS);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [SLOTS];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, depth, depth_sel;
  logic             do_pop, do_push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (!cfg_big)                                 depth_sel = CW'(SMALL_CAP);
    else if (cfg_frame_size <= FSW'(NARROW_MAX))  depth_sel = CW'(SLOTS);
    else if (cfg_frame_size <= FSW'(MID_MAX))     depth_sel = CW'(SLOTS / 2);
    else                                          depth_sel = CW'(SLOTS / 4);
  end

  assign do_pop  = pop && (count != '0) && !clear;
  assign do_push = push && !clear && ((count < depth) || do_pop);

  assign empty     = (count == '0);
  assign full      = (count >= depth);
  assign full_next = (count == depth - 1'b1);
  assign level     = count;
  assign cap       = depth;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      depth     <= CW'(SMALL_CAP);
      pop_data  <= '0;
      pop_err   <= 1'b0;
      push_drop <= 1'b0;
    end else begin
      if (cfg_we) depth <= depth_sel;
      pop_err   <= pop && !clear && (count == '0);
      push_drop <= push && !clear && !do_push;
      if (clear) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (do_push) wr_ptr <= bump(wr_ptr);
        if (do_pop)  rd_ptr <= bump(rd_ptr);
        if (pop)     pop_data <= do_pop ? mem[rd_ptr] : '0;
        count <= count + CW'(do_push) - CW'(do_pop);
      end
    end
  end
endmodule

// File: rtl/adaptive_fifo_chk.sv
module adaptive_fifo_chk #(
  parameter int WIDTH = 32,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             cfg_we,
  input logic             cfg_big,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] pop_data,
  input logic             pop_err,
  input logic             empty,
  input logic             full,
  input logic [CW-1:0]    level,
  input logic [CW-1:0]    cap
);
  AST_SMALL_CAP: assert property (@(posedge clk) disable iff (!rst_n) cfg_we && !cfg_big |=> cap == CW'(4)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push && !pop && !clear && full |=> $stable(level)); // R3
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n) push && !pop && !clear && !full |=> !empty); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) pop && empty && !clear |=> pop_err && pop_data == '0); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) clear |=> empty && !full && level == '0); // R7
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cfg_we |=> $stable(cap)); // R8
  AST_PAIR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) push && pop && !empty && !clear |=> $stable(level)); // R9
endmodule

bind adaptive_fifo adaptive_fifo_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_we(cfg_we), .cfg_big(cfg_big),
  .push(push), .pop(pop), .pop_data(pop_data), .pop_err(pop_err),
  .empty(empty), .full(full), .level(level), .cap(cap)
);

// File: tb/adaptive_fifo_bench.sv
module adaptive_fifo_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        clear = 0, cfg_we = 0, cfg_big = 0, push = 0, pop = 0;
  logic [5:0]  cfg_frame_size = 6'd4;
  logic [31:0] push_data = '0;
  logic [31:0] pop_data;
  logic        pop_err, push_drop, empty, full, full_next;
  logic [5:0]  level, cap;

  int checks = 0, fails = 0;
  int cap_m = 4;
  logic [31:0] store_q[$];
  logic [32:0] exp_q[$];
  bit drop_m;

  always #5 clk = ~clk;

  adaptive_fifo u_adaptive_fifo (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_we(cfg_we), .cfg_big(cfg_big),
    .cfg_frame_size(cfg_frame_size), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .pop_err(pop_err), .push_drop(push_drop), .empty(empty),
    .full(full), .full_next(full_next), .level(level), .cap(cap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit pu, input logic [31:0] d, input bit po, input bit cl = 0);
    bit took;
    drop_m = 0;
    if (cl) store_q.delete();
    else begin
      took = po && store_q.size() > 0;
      if (po) exp_q.push_back(took ? {1'b0, store_q[0]} : {1'b1, 32'h0});
      if (pu && (store_q.size() < cap_m || took)) begin
        if (took) void'(store_q.pop_front());
        store_q.push_back(d);
      end else begin
        if (took) void'(store_q.pop_front());
        drop_m = pu;
      end
    end
    push = pu; push_data = d; pop = po; clear = cl;
    @(negedge clk);
    push = 0; pop = 0; clear = 0;
  endtask

  task automatic config_cap(input bit big, input logic [5:0] fs, input int expc, input string req);
    cfg_big = big; cfg_frame_size = fs; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    cap_m = expc;
    chk(req, 32'(cap), 32'(expc));
  endtask

  task automatic flags(input string req);
    int n = store_q.size();
    chk({req, " level"}, 32'(level), 32'(n));
    chk({req, " empty"}, 32'(empty), 32'(n == 0));
    chk({req, " full"}, 32'(full), 32'(n >= cap_m));
    chk({req, " full_next"}, 32'(full_next), 32'(n == cap_m - 1));
  endtask

  // monitor: compare read data against scoreboard
  initial begin
    logic [32:0] e;
    forever begin
      @(posedge clk);
      if (pop && !clear) begin
        @(negedge clk);
        e = exp_q.pop_front();
        chk("R10 pop_data", pop_data, e[31:0]);
        chk("R6 pop_err", 32'(pop_err), 32'(e[32]));
      end
    end
  end

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state, R1 reset capacity
    chk("R11 cap", 32'(cap), 32'd4);
    chk("R11 pop_err", 32'(pop_err), 0);
    chk("R11 push_drop", 32'(push_drop), 0);
    flags("R11");

    // R4 R5 small capacity fill
    for (int i = 0; i < 4; i++) begin
      cyc(1, 32'hA000 + 32'(i), 0);
      flags("R4 R5 fill");
    end
    // R3 overflow drop
    cyc(1, 32'hDEAD, 0);
    chk("R3 push_drop", 32'(push_drop), 32'(drop_m));
    flags("R3");
    // R10 drain, R5 empty at end
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1);
      flags("R10 drain");
    end
    // R6 empty read
    cyc(0, 0, 1);
    flags("R6");
    @(negedge clk);
    chk("R6 pop_err drops", 32'(pop_err), 0);

    // R2 thresholds, R1 width ignored when small
    config_cap(1, 6'd8, 32, "R2 fs8");
    config_cap(1, 6'd9, 16, "R2 fs9");
    config_cap(1, 6'd17, 8, "R2 fs17");
    config_cap(1, 6'd32, 8, "R2 fs32");
    config_cap(1, 6'd1, 32, "R2 fs1");
    config_cap(0, 6'd20, 4, "R1 small");
    config_cap(1, 6'd16, 16, "R2 fs16");
    // R8 pins without write
    cfg_big = 0; cfg_frame_size = 6'd3;
    repeat (2) @(negedge clk);
    chk("R8 no write", 32'(cap), 32'd16);

    // fill 16, R3 drop, R9 pair while full
    for (int i = 0; i < 16; i++) cyc(1, 32'hB000 + 32'(i), 0);
    flags("R5 full16");
    cyc(1, 32'hBAD0, 0);
    chk("R3 drop16", 32'(push_drop), 1);
    cyc(1, 32'hC001, 1);
    chk("R9 no drop", 32'(push_drop), 0);
    flags("R9 pair");

    // R8 shrink below level
    config_cap(1, 6'd20, 8, "R8 shrink");
    flags("R8 after shrink");
    for (int i = 0; i < 9; i++) begin
      cyc(0, 0, 1);
      flags("R8 drain");
    end
    // R7 clear wins over requests
    cyc(1, 32'hEEEE, 1, 1);
    flags("R7 clear");
    chk("R7 no drop", 32'(push_drop), 0);
    cyc(1, 32'h1234, 0);
    cyc(0, 0, 1);
    flags("R7 after");
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule